// File: doc/BRIEF.md
# Dual-Channel Serial Converter Word Loader

This block is the digital front end of a dual 12-bit converter. A host shifts one 24-bit frame in over a serial data pin. Shifting happens while chip select is low, one bit on each rising edge of the serial clock. The frame carries the words for both channels. The first twelve bits shifted are the channel B word and the last twelve are the channel A word, each sent most significant bit first.

Each channel has a load strobe of its own. A strobe copies that channel's half of the shift register into the channel's output register. Because the strobes are separate, the host can refresh one channel and leave the other alone, or raise both strobes in the same cycle so that both outputs change on the same clock edge. An asynchronous clear forces both output codes, and the shift register, to zero. A host uses it at power-up or before a calibration pass.

All serial pins are taken to be synchronous to the block clock already. The serial clock is sampled, and only its rising transitions are acted on. The two 12-bit output codes are meant to drive the converter cores directly.

Top module: `dual_dac_loader`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a clock edge, both output codes and the shift register become zero.
- R2: With `cs_n_i` low, each low-to-high transition of `sclk_i` (as seen at the block clock) shifts `sdi_i` into bit 0 of the 24-bit shift register, and every older bit moves up one place. After 24 shifts, bits 23..12 hold the first twelve bits sent (channel B word, MSB first) and bits 11..0 hold the last twelve (channel A word, MSB first).
- R3: While `cs_n_i` is high, `sclk_i` transitions do not change the shift register.
- R4: A clock edge with `load_a_i` high and `cs_n_i` low copies shift bits 11..0 into `code_a_o`. A clock edge with `load_b_i` high and `cs_n_i` low copies shift bits 23..12 into `code_b_o`. The other channel is unaffected.
- R5: When `load_a_i` and `load_b_i` are both high with `cs_n_i` low, both outputs take their new words on the same clock edge.
- R6: While `cs_n_i` is high, `load_a_i` and `load_b_i` have no effect on the outputs.
- R7: `clr_i` high zeroes both output codes and the shift register at once, without waiting for a clock edge. While it is high it overrides any load.
- R8: With no accepted load, no clear and no reset, each output code holds its value.
- R9: Raising `cs_n_i` partway through a frame keeps the bits already shifted. Shifting resumes from them when `cs_n_i` falls again.
- R10: Holding `sclk_i` high for many clock cycles shifts only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Asynchronous clear of both codes and the shift register, active high |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, sampled by `clk` |
| sdi_i | input | 1 | Serial data in |
| load_a_i | input | 1 | Load strobe for channel A |
| load_b_i | input | 1 | Load strobe for channel B |
| code_a_o | output | 12 | Channel A output code |
| code_b_o | output | 12 | Channel B output code |

## Verification
Four properties are checked on every cycle:

- each output code holds unless a load is accepted for it;
- an accepted load puts the matching half of the shift register on the output in the next cycle;
- the shift register stays still while chip select is high;
- clear leaves both codes at zero.

Several behaviours can only be shown by the bench's scenarios, because they depend on a whole sequence of serial bits:

- the frame ordering and most-significant-bit-first packing;
- a partial frame surviving a chip-select release;
- a long serial-clock high shifting only once;
- clear acting between clock edges;
- reset and clear also emptying the shift register.

// File: rtl/dacld_pkg.sv
// Package: shared sizes and channel indices for the dual converter word loader.
// Assumes exactly two channels whose words share one serial frame.
package dacld_pkg;
    // Default width of one channel's code.
    localparam int DEF_CODE_W = 12;
    // Number of channels carried by one frame.
    localparam int NUM_CH = 2;

    // Channel index; also the field index inside the shift register
    // (channel A occupies the low field, channel B the high field).
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;
endpackage

// File: rtl/dacld_edge.sv
// Module: rising-transition detector for a sampled serial clock.
// Assumes the input is already synchronous to clk; reports one pulse per
// low-to-high change, however long the level stays high afterwards.
module dacld_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    // Remember the previous sampled level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig_i;
        end
    end

    // A rise is a high level now that was low one cycle ago.
    always_comb begin
        rise_o = sig_i & ~sig_q;
    end
endmodule

// File: rtl/dacld_shift.sv
// Module: serial-in shift register holding one full frame.
// New bits enter at bit 0 and older bits move towards the top, so the first
// bit of a frame ends in the most significant position. Clear is asynchronous.
module dacld_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               shift_en_i,
    input  logic               sdi_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] frame_nxt;

    // Next frame value: shift one place up and append the new bit.
    always_comb begin
        frame_nxt = {frame_q[FRAME_W-2:0], sdi_i};
    end

    // Frame storage: clear, reset, shift on enable, otherwise hold.
    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i) begin
            frame_q <= '0;
        end else if (!rst_n) begin
            frame_q <= '0;
        end else if (shift_en_i) begin
            frame_q <= frame_nxt;
        end
    end

    assign frame_o = frame_q;
endmodule

// File: rtl/dacld_chan.sv
// Module: one channel's output code register.
// Takes a new code when its load enable is high at a clock edge; clear zeroes
// it at once and beats both reset and load.
module dacld_chan #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] code_q;

    // Code storage with asynchronous clear taking priority.
    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i) begin
            code_q <= '0;
        end else if (!rst_n) begin
            code_q <= '0;
        end else if (load_i) begin
            code_q <= code_i;
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/dual_dac_loader.sv
// Module: top of the dual-channel serial loader.
// Samples the serial clock, shifts a two-word frame while chip select is low,
// and copies each channel's field to its output register on that channel's
// load strobe. Assumes all serial pins are synchronous to clk.
module dual_dac_loader #(
    parameter int CODE_W = dacld_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              load_a_i,
    input  logic              load_b_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o
);
    import dacld_pkg::*;

    localparam int FRAME_W = NUM_CH * CODE_W;

    logic                  sclk_rise;
    logic                  shift_en;
    logic [FRAME_W-1:0]    shift_q;
    logic [NUM_CH-1:0]     load_req;
    logic [NUM_CH-1:0]     load_ok;
    logic [CODE_W-1:0]     code_arr [NUM_CH];

    // Serial clock edge detection.
    dacld_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sclk_i),
        .rise_o (sclk_rise)
    );

    // Shift only on a serial clock rise while selected.
    always_comb begin
        shift_en = sclk_rise & ~cs_n_i;
    end

    dacld_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .shift_en_i (shift_en),
        .sdi_i      (sdi_i),
        .frame_o    (shift_q)
    );

    // Gather the per-channel load strobes into a vector indexed by channel.
    always_comb begin
        load_req         = '0;
        load_req[CH_A]   = load_a_i;
        load_req[CH_B]   = load_b_i;
    end

    // One output register per channel, fed from its own field of the frame.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        // Accept a strobe only while chip select is active.
        always_comb begin
            load_ok[ch] = load_req[ch] & ~cs_n_i;
        end

        dacld_chan #(
            .CODE_W (CODE_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_i),
            .load_i (load_ok[ch]),
            .code_i (shift_q[ch*CODE_W +: CODE_W]),
            .code_o (code_arr[ch])
        );
    end

    assign code_a_o = code_arr[CH_A];
    assign code_b_o = code_arr[CH_B];
endmodule

// File: rtl/dacld_checker.sv
// Module: property checker for the dual-channel loader, bound to its top.
// Observes ports and the shift register that feeds the channel registers.
module dacld_checker #(
    parameter int CODE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr_i,
    input logic                cs_n_i,
    input logic                load_a_i,
    input logic                load_b_i,
    input logic [2*CODE_W-1:0] shift_q,
    input logic [CODE_W-1:0]   code_a_o,
    input logic [CODE_W-1:0]   code_b_o
);
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (!(load_a_i && !cs_n_i)) |=> $stable(code_a_o)); // R8
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (!(load_b_i && !cs_n_i)) |=> $stable(code_b_o)); // R8
    AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (load_a_i && !cs_n_i) |=> (code_a_o == $past(shift_q[CODE_W-1:0]))); // R4
    AST_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (load_b_i && !cs_n_i) |=> (code_b_o == $past(shift_q[2*CODE_W-1:CODE_W]))); // R4
    AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        cs_n_i |=> $stable(shift_q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> (code_a_o == '0 && code_b_o == '0)); // R7
endmodule

bind dual_dac_loader dacld_checker #(.CODE_W(CODE_W)) u_dacld_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .cs_n_i   (cs_n_i),
    .load_a_i (load_a_i),
    .load_b_i (load_b_i),
    .shift_q  (shift_q),
    .code_a_o (code_a_o),
    .code_b_o (code_b_o)
);

// File: tb/test_dual_dac_loader.sv
// Bench: directed scenarios for the dual-channel loader; each task checks
// its own results at the falling clock edge.
module test_dual_dac_loader;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_i = 1'b0;
    logic         cs_n_i = 1'b1;
    logic         sclk_i = 1'b0;
    logic         sdi_i = 1'b0;
    logic         load_a_i = 1'b0;
    logic         load_b_i = 1'b0;
    logic [W-1:0] code_a_o;
    logic [W-1:0] code_b_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_dac_loader #(.CODE_W(W)) i_dual_dac_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .cs_n_i   (cs_n_i),
        .sclk_i   (sclk_i),
        .sdi_i    (sdi_i),
        .load_a_i (load_a_i),
        .load_b_i (load_b_i),
        .code_a_o (code_a_o),
        .code_b_o (code_b_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Shift 'nbits' bits of 'bits', MSB first; sclk high lasts 'hi' cycles.
    task automatic shift_bits(input logic [2*W-1:0] bits, input int nbits, input int hi);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi_i  = bits[i];
            sclk_i = 1'b0;
            repeat (2) @(negedge clk);
            sclk_i = 1'b1;
            repeat (hi) @(negedge clk);
        end
        sclk_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [W-1:0] wb, input logic [W-1:0] wa, input int hi);
        cs_n_i = 1'b0;
        shift_bits({wb, wa}, 2 * W, hi);
    endtask

    task automatic pulse_load(input logic la, input logic lb);
        load_a_i = la;
        load_b_i = lb;
        @(negedge clk);
        load_a_i = 1'b0;
        load_b_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset code_a", code_a_o, '0);
        check("R1 reset code_b", code_b_o, '0);
        send_frame(12'h321, 12'h654, 1);
        pulse_load(1, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset code_a", code_a_o, '0);
        check("R1 mid reset code_b", code_b_o, '0);
        pulse_load(1, 1);
        check("R1 shift emptied by reset", code_a_o | code_b_o, '0);
    endtask

    task automatic t_separate();
        send_frame(12'hABC, 12'h123, 1);
        pulse_load(1, 0);
        check("R4 load A", code_a_o, 12'h123);
        check("R8 B held while A loads", code_b_o, '0);
        pulse_load(0, 1);
        check("R2 frame order B field", code_b_o, 12'hABC);
        check("R8 A held while B loads", code_a_o, 12'h123);
        repeat (5) @(negedge clk);
        check("R8 A hold idle", code_a_o, 12'h123);
    endtask

    task automatic t_both();
        send_frame(12'h5A5, 12'hF0F, 1);
        load_a_i = 1'b1;
        load_b_i = 1'b1;
        @(posedge clk);
        #1;
        check("R5 same-edge A", code_a_o, 12'hF0F);
        check("R5 same-edge B", code_b_o, 12'h5A5);
        @(negedge clk);
        load_a_i = 1'b0;
        load_b_i = 1'b0;
    endtask

    task automatic t_deselected();
        send_frame(12'h1E1, 12'h2D2, 1);
        cs_n_i = 1'b1;
        pulse_load(1, 1);
        check("R6 load ignored A", code_a_o, 12'hF0F);
        check("R6 load ignored B", code_b_o, 12'h5A5);
        shift_bits(24'hFFFFFF, 2 * W, 1);
        cs_n_i = 1'b0;
        @(negedge clk);
        pulse_load(1, 1);
        check("R3 sclk ignored A", code_a_o, 12'h2D2);
        check("R3 sclk ignored B", code_b_o, 12'h1E1);
    endtask

    task automatic t_partial();
        cs_n_i = 1'b0;
        shift_bits({12'h000, 12'h7C3}, W, 1);
        cs_n_i = 1'b1;
        repeat (4) @(negedge clk);
        cs_n_i = 1'b0;
        shift_bits({12'h000, 12'h96E}, W, 1);
        pulse_load(1, 1);
        check("R9 partial frame B", code_b_o, 12'h7C3);
        check("R9 partial frame A", code_a_o, 12'h96E);
    endtask

    task automatic t_long_high();
        send_frame(12'hC0D, 12'hE5B, 6);
        pulse_load(1, 1);
        check("R10 long high A", code_a_o, 12'hE5B);
        check("R10 long high B", code_b_o, 12'hC0D);
    endtask

    task automatic t_clear();
        #1;
        clr_i = 1'b1;
        #0.5;
        check("R7 async clear A", code_a_o, '0);
        check("R7 async clear B", code_b_o, '0);
        @(negedge clk);
        clr_i = 1'b0;
        send_frame(12'h444, 12'h888, 1);
        clr_i    = 1'b1;
        load_a_i = 1'b1;
        load_b_i = 1'b1;
        @(negedge clk);
        clr_i    = 1'b0;
        load_a_i = 1'b0;
        load_b_i = 1'b0;
        check("R7 clear beats load A", code_a_o, '0);
        check("R7 clear beats load B", code_b_o, '0);
        pulse_load(1, 1);
        check("R7 shift emptied by clear", code_a_o | code_b_o, '0);
    endtask

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_separate();
        t_both();
        t_deselected();
        t_partial();
        t_long_high();
        t_clear();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule